// File: doc/BRIEF.md
# Converter Serial Result Shifter

This block sends a finished conversion word out of a data-converter core as a serial bitstream timed by a data clock. The conversion controller presents each completed result together with a one-cycle completion strobe. The block keeps that word in a holding register. A one-cycle start strobe, the same event that begins the next conversion, copies the held word into a separate shift register. The word leaves most significant bit first, one bit per data-clock period. Because the holding register and the shift register are separate, a conversion that completes mid-transfer cannot disturb the bits already in flight.

A source-select input picks who owns the data clock. When the select is low, the block divides its system clock by a parameter and drives a burst of exactly one word's worth of data-clock pulses. When the select is high, the block stops driving the clock and follows an external data clock, which it samples through a synchroniser. In external mode a tag input is shifted in behind the result. Once the word has gone out, the serial output repeats the tag stream sixteen clocks late, so several converters can share one serial line in a daisy chain.

Top module: `ser_result_shifter`

## Requirements
- R1: While reset is asserted on a clock edge, the serial output and the driven data clock are both low after that edge. Both the holding word and the shift word read back as zero afterwards.
- R2: With source select low (internal clock), a start strobe produces exactly 16 data-clock pulses. The first rising edge comes DIV/2 system cycles after the start edge, later rising edges are DIV cycles apart, and the clock then stays low.
- R3: In internal mode the serial output shows the MSB from the start edge onward. It moves to the next lower bit on the same system edge on which the data clock falls, so it never changes while the data clock is high. Pulse k (counting from 1) carries bit 16-k.
- R4: A start strobe sends the word from the most recent completion strobe before it. A completion strobe in the same cycle as the start affects only the next transfer. A completion strobe during a transfer does not change the bits still to be sent.
- R5: In internal mode zeros are shifted in behind the word, so the serial output is low once the 16th pulse has ended.
- R6: With source select high (external clock), the clock drive-enable output is low and the driven clock stays low. A start strobe still loads the word and shows its MSB but produces no pulses. Each falling edge of the external clock moves the output to the next bit, MSB first.
- R7: In external mode the tag value present at each external falling edge is shifted in behind the word. After the 16 result bits, the output in external period 16+j equals the tag value captured in period j.
- R8: A start strobe during an internal transfer abandons that transfer and begins a fresh 16-pulse transfer from the MSB of the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | WORD_W | Finished conversion word |
| result_vld_i | input | 1 | One-cycle strobe: result_i holds a new completed word |
| start_i | input | 1 | One-cycle start event from the conversion controller |
| ext_sel_i | input | 1 | Data-clock source: 0 block drives clock, 1 external clock |
| dclk_ext_i | input | 1 | External data clock (asynchronous, sampled) |
| tag_i | input | 1 | Daisy-chain serial input used with the external clock |
| sdata_o | output | 1 | Serial data, MSB first |
| dclk_o | output | 1 | Data clock driven by the block in internal mode |
| dclk_oe_o | output | 1 | High when the block drives the data clock |

## Verification
Internal transfers use the words A5C3, 0001, 8000 and FFFF. A lone one at each end exposes reversed bit order or an off-by-one in the pulse count, while all-ones and a mixed pattern expose stuck or lost shifts and trailing fill. Completion strobes are placed before the start, in the same cycle as the start and mid-transfer, which tells a shared register apart from a separate holding register. A restart after three pulses checks that the pulse counter and the shift state clear together. External runs send a word followed by a distinct tag pattern over 32 external periods, which separates correct tag delay and ordering from a zero fill or a shift on the wrong clock edge.

// File: rtl/ser_shift_pkg.sv
// Shared types and helpers for the serial result shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package ser_shift_pkg;

    // Who owns the data clock.
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } dclk_src_e;

    // Counter width for a count of n states; never narrower than one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ser_dclk_gen.sv
// Internal data-clock generator: on start, emits WORD_W pulses of DIV system
// cycles each (low half first), then idles low. fall_o flags the system
// edge on which the data clock falls. A low en_i clears all state.
// Assumes: DIV is even and >= 2; start_i is a one-cycle strobe.
module ser_dclk_gen
    import ser_shift_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    output logic dclk_o,
    output logic fall_o
);

    localparam int HALF = DIV / 2;
    localparam int PW   = cnt_width(HALF);
    localparam int BW   = cnt_width(WORD_W);

    logic          active;
    logic          dclk_q;
    logic [PW-1:0] phase;
    logic [BW-1:0] bits;
    logic          phase_end;
    logic          last_bit;

    assign phase_end = (phase == PW'(HALF - 1));
    assign last_bit  = (bits == BW'(WORD_W - 1));

    // Half-period counter, clock level and pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            active <= 1'b0;
            dclk_q <= 1'b0;
            phase  <= '0;
            bits   <= '0;
        end else if (start_i) begin
            active <= 1'b1;
            dclk_q <= 1'b0;
            phase  <= '0;
            bits   <= '0;
        end else if (active) begin
            if (phase_end) begin
                phase  <= '0;
                dclk_q <= ~dclk_q;
                if (dclk_q) begin
                    bits <= bits + BW'(1);
                    if (last_bit) begin
                        active <= 1'b0;
                    end
                end
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end

    // Falling-edge flag and gated clock output.
    always_comb begin
        fall_o = active && phase_end && dclk_q;
        dclk_o = dclk_q && en_i;
    end

endmodule

// File: rtl/ser_ext_sync.sv
// Brings the external data clock and tag input into the system clock domain
// through SYNC_STAGES flops and flags each falling edge of the external clock.
// The tag goes through the same depth, so it stays aligned with the edge flag.
// Assumes: each external clock phase lasts several system cycles.
module ser_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic tag_i,
    output logic fall_o,
    output logic tag_o
);

    logic [SYNC_STAGES-1:0] clk_pipe;
    logic [SYNC_STAGES-1:0] tag_pipe;
    logic                   clk_prev;

    // Synchroniser chains, one flop per stage.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_pipe[0] <= 1'b0;
                        tag_pipe[0] <= 1'b0;
                    end else begin
                        clk_pipe[0] <= dclk_i;
                        tag_pipe[0] <= tag_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_pipe[s] <= 1'b0;
                        tag_pipe[s] <= 1'b0;
                    end else begin
                        clk_pipe[s] <= clk_pipe[s-1];
                        tag_pipe[s] <= tag_pipe[s-1];
                    end
                end
            end
        end
    endgenerate

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
        end else begin
            clk_prev <= clk_pipe[SYNC_STAGES-1];
        end
    end

    // Falling-edge flag and aligned tag.
    always_comb begin
        fall_o = clk_prev && !clk_pipe[SYNC_STAGES-1];
        tag_o  = tag_pipe[SYNC_STAGES-1];
    end

endmodule

// File: rtl/ser_word_shifter.sv
// Holding register plus shift register. cap_i stores a finished word.
// load_i copies the held word into the shift register, which takes priority
// over shift_i. shift_i moves the word one place towards the MSB and takes
// fill_i into the LSB. msb_o is the serial output.
// Assumes: strobes are synchronous to clk.
module ser_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              fill_i,
    output logic              msb_o
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shift_q;

    // Keep the latest finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap_i) begin
            hold_q <= word_i;
        end
    end

    // Load on start, otherwise shift on a data-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load_i) begin
            shift_q <= hold_q;
        end else if (shift_i) begin
            shift_q <= {shift_q[WORD_W-2:0], fill_i};
        end
    end

    // Serial output is the top bit.
    always_comb begin
        msb_o = shift_q[WORD_W-1];
    end

endmodule

// File: rtl/ser_result_shifter.sv
// Top of the serial result shifter. Selects between the internal clock
// generator and the synchronised external clock, steers the shift strobe
// and the fill bit, and drives the clock enable.
// Assumes: start_i and result_vld_i are one-cycle strobes; DIV even >= 2.
module ser_result_shifter
    import ser_shift_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] result_i,
    input  logic              result_vld_i,
    input  logic              start_i,
    input  logic              ext_sel_i,
    input  logic              dclk_ext_i,
    input  logic              tag_i,
    output logic              sdata_o,
    output logic              dclk_o,
    output logic              dclk_oe_o
);

    dclk_src_e src;
    logic      int_en;
    logic      fall_int;
    logic      fall_ext;
    logic      tag_sync;
    logic      shift_en;
    logic      fill_bit;

    // Decode the clock source.
    always_comb begin
        src    = dclk_src_e'(ext_sel_i);
        int_en = (src == SRC_INT);
    end

    ser_dclk_gen #(
        .WORD_W (WORD_W),
        .DIV    (DIV)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (int_en),
        .start_i (start_i),
        .dclk_o  (dclk_o),
        .fall_o  (fall_int)
    );

    ser_ext_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dclk_i (dclk_ext_i),
        .tag_i  (tag_i),
        .fall_o (fall_ext),
        .tag_o  (tag_sync)
    );

    // Shift strobe and fill bit follow the active clock source.
    always_comb begin
        shift_en  = int_en ? fall_int : fall_ext;
        fill_bit  = int_en ? 1'b0 : tag_sync;
        dclk_oe_o = int_en;
    end

    ser_word_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (result_vld_i),
        .word_i  (result_i),
        .load_i  (start_i),
        .shift_i (shift_en),
        .fill_i  (fill_bit),
        .msb_o   (sdata_o)
    );

endmodule

// File: rtl/ser_result_shifter_chk.sv
// Property checker for ser_result_shifter, attached with bind below.
// Counts internal data-clock rising edges since the last start so the pulse
// limit is checked without deep temporal operators.
module ser_result_shifter_chk #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ext_sel_i,
    input logic dclk_o,
    input logic sdata_o
);

    localparam int CW = $clog2(WORD_W + 2);

    logic [CW-1:0] rise_cnt;
    logic          dclk_prev;

    // Rising-edge counter, cleared by an internal-mode start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt  <= '0;
            dclk_prev <= 1'b0;
        end else begin
            dclk_prev <= dclk_o;
            if (start_i && !ext_sel_i) begin
                rise_cnt <= '0;
            end else if (!dclk_prev && dclk_o) begin
                rise_cnt <= rise_cnt + CW'(1);
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dclk_o && !sdata_o)); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ext_sel_i) |=> !dclk_o); // R2

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= CW'(WORD_W)); // R2

    AST_BIT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel_i && dclk_o && $past(dclk_o)) |-> $stable(sdata_o)); // R3

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel_i && $past(ext_sel_i)) |-> !dclk_o); // R6

endmodule

bind ser_result_shifter ser_result_shifter_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ext_sel_i (ext_sel_i),
    .dclk_o    (dclk_o),
    .sdata_o   (sdata_o)
);

// File: tb/sim_ser_result_shifter.sv
`timescale 1ns/1ps
// Directed bench for ser_result_shifter: one task per scenario.
module sim_ser_result_shifter;

    localparam int W    = 16;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int EXTP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] result_i = '0;
    logic         result_vld_i = 1'b0;
    logic         start_i = 1'b0;
    logic         ext_sel_i = 1'b0;
    logic         dclk_ext_i = 1'b0;
    logic         tag_i = 1'b0;
    logic         sdata_o;
    logic         dclk_o;
    logic         dclk_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ser_result_shifter #(.WORD_W(W), .DIV(DIV)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .result_i     (result_i),
        .result_vld_i (result_vld_i),
        .start_i      (start_i),
        .ext_sel_i    (ext_sel_i),
        .dclk_ext_i   (dclk_ext_i),
        .tag_i        (tag_i),
        .sdata_o      (sdata_o),
        .dclk_o       (dclk_o),
        .dclk_oe_o    (dclk_oe_o)
    );

    // Record one check, report a miscompare.
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a finished word for one cycle.
    task automatic load_word(input logic [W-1:0] w);
        @(negedge clk);
        result_i     = w;
        result_vld_i = 1'b1;
        @(negedge clk);
        result_vld_i = 1'b0;
    endtask

    // One-cycle start; returns at the negedge after the start edge.
    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Watch an internal transfer started at the last edge and check it.
    task automatic capture_int(input logic [W-1:0] exp, input string req,
                               input int vld_at, input logic [W-1:0] vld_word);
        int       rises = 0;
        int       last_rise = -1;
        int       first = -1;
        int       bad_per = 0;
        int       unstable = 0;
        logic     prev = 1'b0;
        logic     cur_bit = 1'b0;
        logic [W-1:0] got = '0;
        for (int n = 0; n < W * DIV + 8; n++) begin
            if (result_vld_i) result_vld_i = 1'b0;
            if (!prev && dclk_o) begin
                rises++;
                if (first < 0) first = n;
                else if (n - last_rise != DIV) bad_per++;
                last_rise = n;
                cur_bit = sdata_o;
                if (rises <= W) got[W - rises] = sdata_o;
                if (rises == vld_at) begin
                    result_i     = vld_word;
                    result_vld_i = 1'b1;
                end
            end else if (prev && dclk_o && sdata_o != cur_bit) begin
                unstable++;
            end
            prev = dclk_o;
            @(negedge clk);
        end
        chk(rises == W, {req, " R2 pulse count"}, rises, W);
        chk(first == HALF, {req, " R2 first rise"}, first, HALF);
        chk(bad_per == 0, {req, " R2 period"}, bad_per, 0);
        chk(unstable == 0, {req, " R3 hold while high"}, unstable, 0);
        chk(got == exp, {req, " R3 bits"}, got, exp);
        chk(dclk_o == 1'b0, {req, " R2 idle low"}, dclk_o, 0);
        chk(sdata_o == 1'b0, {req, " R5 zero fill"}, sdata_o, 0);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdata_o == 1'b0, "R1 sdata", sdata_o, 0);
        chk(dclk_o == 1'b0, "R1 dclk", dclk_o, 0);
        rst_n = 1'b1;
        pulse_start();
        capture_int('0, "R1 held word zero", 0, '0);
    endtask

    // R2 R3 R5: plain internal transfer.
    task automatic t_internal(input logic [W-1:0] w);
        load_word(w);
        pulse_start();
        chk(sdata_o == w[W-1], "R3 msb at start", sdata_o, w[W-1]);
        capture_int(w, "R2/R3 internal", 0, '0);
    endtask

    // R4: completion strobes during and with the start.
    task automatic t_overlap();
        load_word(16'h1234);
        pulse_start();
        capture_int(16'h1234, "R4 mid-transfer completion", 5, 16'hBEEF);
        pulse_start();
        capture_int(16'hBEEF, "R4 next word", 0, '0);
        @(negedge clk);
        result_i     = 16'h5A5A;
        result_vld_i = 1'b1;
        start_i      = 1'b1;
        @(negedge clk);
        result_vld_i = 1'b0;
        start_i      = 1'b0;
        capture_int(16'hBEEF, "R4 same-cycle start", 0, '0);
        pulse_start();
        capture_int(16'h5A5A, "R4 after same-cycle", 0, '0);
    endtask

    // R8: restart mid-transfer.
    task automatic t_restart();
        int   r = 0;
        logic p = 1'b0;
        load_word(16'hC3A5);
        pulse_start();
        while (r < 3) begin
            if (!p && dclk_o) r++;
            p = dclk_o;
            @(negedge clk);
        end
        pulse_start();
        capture_int(16'hC3A5, "R8 restart", 0, '0);
    endtask

    // R6 R7: external clock with tag daisy chain.
    task automatic t_external(input logic [W-1:0] w, input logic [W-1:0] tpat);
        int quiet = 0;
        logic expb;
        load_word(w);
        @(negedge clk);
        ext_sel_i  = 1'b1;
        dclk_ext_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(dclk_oe_o == 1'b0, "R6 drive enable", dclk_oe_o, 0);
        pulse_start();
        for (int n = 0; n < 20; n++) begin
            if (dclk_o) quiet++;
            @(negedge clk);
        end
        chk(quiet == 0, "R6 no pulses", quiet, 0);
        chk(sdata_o == w[W-1], "R6 msb loaded", sdata_o, w[W-1]);
        for (int i = 0; i < 2 * W; i++) begin
            tag_i      = (i < W) ? tpat[W-1-i] : 1'b0;
            dclk_ext_i = 1'b1;
            repeat (EXTP) @(negedge clk);
            expb = (i < W) ? w[W-1-i] : tpat[W-1-(i-W)];
            chk(sdata_o == expb, (i < W) ? "R6 ext result bit" : "R7 tag bit", sdata_o, expb);
            dclk_ext_i = 1'b0;
            repeat (EXTP) @(negedge clk);
        end
        ext_sel_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(dclk_oe_o == 1'b1, "R6 drive enable back", dclk_oe_o, 1);
    endtask

    // Stimulus sequence.
    initial begin
        t_reset();
        t_internal(16'hA5C3);
        t_internal(16'h0001);
        t_internal(16'h8000);
        t_internal(16'hFFFF);
        t_overlap();
        t_restart();
        t_external(16'h9E37, 16'hD00B);
        t_external(16'h0F0F, 16'h8001);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule